// File: doc/BRIEF.md
# Presence-Vector Directory Coherence Controller

This block sits on the memory side of a small multiprocessor and keeps caches coherent without broadcasting. For each memory block it holds one presence bit per processing element (PE) and a single dirty bit, alongside a one-word data store. A PE asks for a block either to read it or to gain ownership so it can write it. The controller looks up the entry and sends targeted messages only to the PEs whose presence bits are set. A message either invalidates a copy, or recalls the line and keeps it as a shared copy, or recalls it and invalidates it. The controller collects one acknowledgement from each targeted PE, updates the directory and the store, and then answers the requester with the block's current data.

A write request is a read-for-ownership. The requester receives the current data and becomes the sole, dirty holder. Memory is updated only when a dirty line is recalled, so the latest value can live in an owner's cache. The controller handles one transaction at a time. Requests that arrive while one is in flight wait in a queue and are served in arrival order.

Top module: `dir_ctrl`

## Requirements
- R1: After reset no response or message is asserted, every directory entry is empty and clean, and block a holds data INIT_BASE + a.
- R2: A read of a clean block is answered from the store with no message to any PE, and the requester is recorded as a sharer.
- R3: A read of a dirty block sends one recall-keep-shared message (cmd_kind 1) to the owner only. The data the owner acknowledges with is delivered to the requester and copied into the store, and the block becomes clean, so a later read needs no message.
- R4: A write request for a clean block sends an invalidate message (cmd_kind 0) to every sharer other than the requester and to no other PE. The response carries the store's data.
- R5: A write request for a dirty block sends one recall-and-invalidate message (cmd_kind 2) to the owner only, and the response carries the owner's returned data.
- R6: After a write request the requester is the only PE marked present, so a later write request invalidates only PEs that became sharers since then.
- R7: The response is not given before every targeted PE has acknowledged, even when acknowledgements arrive late and in different cycles.
- R8: Messages are single-cycle pulses, at most one PE receives a response in any cycle, and only one transaction is in progress at a time.
- R9: Queued requests are served in arrival order. Requests arriving in the same cycle are served lowest PE index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_PE | One-cycle request pulse per PE; at most one outstanding per PE |
| req_write | input | NUM_PE | Per-PE request type: 1 = ownership for write, 0 = read |
| req_addr | input | NUM_PE*ADDR_W | Per-PE block address, PE p in slice p |
| cmd_valid | output | NUM_PE | One-hot-or-more message pulse to the targeted PEs |
| cmd_kind | output | 2 | 0 invalidate, 1 recall keep shared, 2 recall and invalidate |
| cmd_addr | output | ADDR_W | Block address of the message |
| ack_valid | input | NUM_PE | Per-PE acknowledgement pulse |
| ack_data | input | NUM_PE*DATA_W | Per-PE line data returned with a recall acknowledgement |
| rsp_valid | output | NUM_PE | Response pulse to the requester |
| rsp_data | output | DATA_W | Block data delivered with the response |

## Verification
The hardest situations to reach from the ports are those where the directory state for one block builds up over several transactions: a dirty block with an owner that differs from the next requester, and a sharer set left over from a previous ownership change. The bench reaches these by chaining requests from different PEs to the same block, and a cache model in the bench answers messages with the value that PE last wrote. A second hard case is acknowledgements that arrive spread over several cycles. Per-PE acknowledgement delays in the bench responder stretch the wait so the response can be checked against the last acknowledgement.

// File: rtl/dir_pkg.sv
// Shared types of the directory controller: message kinds and engine states.
// Assumes message kind codes are fixed because PE caches decode them.
package dir_pkg;
    typedef enum logic [1:0] {
        CMD_INVAL        = 2'd0,
        CMD_RECALL_SHARE = 2'd1,
        CMD_RECALL_INV   = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } eng_state_e;
endpackage

// File: rtl/dir_arrival_fifo.sv
// Request holding queue. Captures each PE's request fields and keeps PE
// indices in arrival order; same-cycle arrivals enqueue lowest index first.
// Assumes each PE has at most one request outstanding, so NUM_PE slots suffice.
module dir_arrival_fifo #(
    parameter int NUM_PE = 4,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PE-1:0]        push_vec,
    input  logic [NUM_PE-1:0]        push_wr,
    input  logic [NUM_PE*ADDR_W-1:0] push_addr,
    input  logic                     pop,
    output logic                     head_vld,
    output logic [((NUM_PE>1)?$clog2(NUM_PE):1)-1:0] head_pe,
    output logic                     head_wr,
    output logic [ADDR_W-1:0]        head_addr
);
    localparam int PE_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;
    localparam int CNT_W = $clog2(NUM_PE + 1);

    logic [PE_W-1:0]   slot_q [NUM_PE];
    logic [PE_W-1:0]   slot_n [NUM_PE];
    logic [PE_W-1:0]   rd_q, rd_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n, pushes;
    logic [PE_W-1:0]   widx;
    logic [NUM_PE-1:0] hold_wr;
    logic [ADDR_W-1:0] hold_addr [NUM_PE];

    // Place this cycle's arrivals behind the queued ones, in index order.
    always_comb begin
        slot_n = slot_q;
        pushes = '0;
        widx   = '0;
        for (int k = 0; k < NUM_PE; k++) begin
            if (push_vec[k]) begin
                widx = PE_W'((int'(rd_q) + int'(cnt_q) + int'(pushes)) % NUM_PE);
                slot_n[widx] = PE_W'(k);
                pushes = pushes + 1'b1;
            end
        end
    end

    // Advance read pointer and occupancy.
    always_comb begin
        rd_n  = rd_q;
        if (pop) begin
            rd_n = (int'(rd_q) == NUM_PE - 1) ? '0 : rd_q + 1'b1;
        end
        cnt_n = cnt_q + pushes - CNT_W'(pop);
    end

    // Queue state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            cnt_q <= '0;
            for (int k = 0; k < NUM_PE; k++) slot_q[k] <= '0;
        end else begin
            rd_q   <= rd_n;
            cnt_q  <= cnt_n;
            slot_q <= slot_n;
        end
    end

    // Per-PE capture of the request fields.
    for (genvar p = 0; p < NUM_PE; p++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_wr[p]   <= 1'b0;
                hold_addr[p] <= '0;
            end else if (push_vec[p]) begin
                hold_wr[p]   <= push_wr[p];
                hold_addr[p] <= push_addr[p*ADDR_W +: ADDR_W];
            end
        end
    end

    assign head_vld  = (cnt_q != '0);
    assign head_pe   = slot_q[rd_q];
    assign head_wr   = hold_wr[head_pe];
    assign head_addr = hold_addr[head_pe];

    // R9: the queue never holds more entries than there are PEs.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) + int'(pushes) - int'(pop)) <= NUM_PE);
    // R8: the engine only takes a request when one is queued.
    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));
endmodule

// File: rtl/dir_entry_store.sv
// Directory entries (presence vector, dirty bit) and one data word per block.
// Combinational read port and one synchronous write port; reset clears the
// directory and loads block a with INIT_BASE + a.
module dir_entry_store #(
    parameter int          NUM_PE    = 4,
    parameter int          ADDR_W    = 3,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] INIT_BASE = 16'hA000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NUM_PE-1:0] rd_pres,
    output logic              rd_dirty,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              dir_we,
    input  logic [NUM_PE-1:0] wr_pres,
    input  logic              wr_dirty,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_wdata
);
    localparam int BLOCKS = 1 << ADDR_W;

    logic [NUM_PE-1:0] pres_q  [BLOCKS];
    logic              dirty_q [BLOCKS];
    logic [DATA_W-1:0] mem_q   [BLOCKS];

    assign rd_pres  = pres_q[rd_addr];
    assign rd_dirty = dirty_q[rd_addr];
    assign rd_data  = mem_q[rd_addr];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        // Update one block's entry and data word when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q[b]  <= '0;
                dirty_q[b] <= 1'b0;
                mem_q[b]   <= DATA_W'(INIT_BASE) + DATA_W'(b);
            end else if (int'(wr_addr) == b) begin
                if (dir_we) begin
                    pres_q[b]  <= wr_pres;
                    dirty_q[b] <= wr_dirty;
                end
                if (mem_we) mem_q[b] <= mem_wdata;
            end
        end

        // R6: a dirty block has exactly one PE marked present.
        p_single_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
            dirty_q[b] |-> ($countones(pres_q[b]) == 1));
    end
endmodule

// File: rtl/dir_engine.sv
// Transaction engine. Takes one queued request, decides the targets from the
// directory entry, pulses messages, waits for every acknowledgement, then
// writes the entry back and answers the requester.
// Assumes PEs acknowledge each message exactly once, after receiving it.
module dir_engine #(
    parameter int NUM_PE = 4,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     head_vld,
    input  logic [((NUM_PE>1)?$clog2(NUM_PE):1)-1:0] head_pe,
    input  logic                     head_wr,
    input  logic [ADDR_W-1:0]        head_addr,
    output logic                     pop,
    output logic [ADDR_W-1:0]        look_addr,
    input  logic [NUM_PE-1:0]        rd_pres,
    input  logic                     rd_dirty,
    input  logic [DATA_W-1:0]        rd_data,
    output logic                     dir_we,
    output logic [NUM_PE-1:0]        wr_pres,
    output logic                     wr_dirty,
    output logic                     mem_we,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic [NUM_PE-1:0]        cmd_valid,
    output logic [1:0]               cmd_kind,
    output logic [ADDR_W-1:0]        cmd_addr,
    input  logic [NUM_PE-1:0]        ack_valid,
    input  logic [NUM_PE*DATA_W-1:0] ack_data,
    output logic [NUM_PE-1:0]        rsp_valid,
    output logic [DATA_W-1:0]        rsp_data
);
    import dir_pkg::*;
    localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

    eng_state_e        state_q;
    logic [PE_W-1:0]   cur_pe;
    logic              cur_wr;
    logic [ADDR_W-1:0] cur_addr;
    cmd_kind_e         kind_q, kind_c;
    logic              was_dirty_q;
    logic [NUM_PE-1:0] pending_q, keep_q, targets, req_bit;
    logic [DATA_W-1:0] buf_q, recall_data;
    logic              any_recall_ack, acked_all;

    // One-hot form of the requester.
    always_comb begin
        req_bit = '0;
        req_bit[cur_pe] = 1'b1;
    end

    // Targets: other present PEs, unless the read finds the block clean.
    always_comb begin
        targets = (cur_wr || rd_dirty) ? (rd_pres & ~req_bit) : '0;
        if (!cur_wr)       kind_c = CMD_RECALL_SHARE;
        else if (rd_dirty) kind_c = CMD_RECALL_INV;
        else               kind_c = CMD_INVAL;
    end

    // Gather returned line data from acknowledgements still awaited.
    always_comb begin
        recall_data    = '0;
        any_recall_ack = 1'b0;
        for (int p = 0; p < NUM_PE; p++) begin
            if (ack_valid[p] && pending_q[p]) begin
                recall_data    = recall_data | ack_data[p*DATA_W +: DATA_W];
                any_recall_ack = 1'b1;
            end
        end
        acked_all = ((pending_q & ~ack_valid) == '0);
    end

    assign pop       = (state_q == ST_IDLE) && head_vld;
    assign look_addr = cur_addr;
    assign dir_we    = (state_q == ST_DONE);
    assign wr_pres   = cur_wr ? req_bit : (keep_q | req_bit);
    assign wr_dirty  = cur_wr;
    assign mem_we    = (state_q == ST_DONE) && was_dirty_q;
    assign mem_wdata = buf_q;
    assign cmd_kind  = kind_q;

    // Transaction sequencing and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_pe      <= '0;
            cur_wr      <= 1'b0;
            cur_addr    <= '0;
            kind_q      <= CMD_INVAL;
            was_dirty_q <= 1'b0;
            pending_q   <= '0;
            keep_q      <= '0;
            buf_q       <= '0;
            cmd_valid   <= '0;
            cmd_addr    <= '0;
            rsp_valid   <= '0;
            rsp_data    <= '0;
        end else begin
            cmd_valid <= '0;
            rsp_valid <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (head_vld) begin
                        cur_pe   <= head_pe;
                        cur_wr   <= head_wr;
                        cur_addr <= head_addr;
                        state_q  <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    buf_q       <= rd_data;
                    keep_q      <= rd_pres;
                    was_dirty_q <= rd_dirty;
                    kind_q      <= kind_c;
                    pending_q   <= targets;
                    cmd_valid   <= targets;
                    cmd_addr    <= cur_addr;
                    state_q     <= (targets == '0) ? ST_DONE : ST_WAIT;
                end
                ST_WAIT: begin
                    pending_q <= pending_q & ~ack_valid;
                    if (any_recall_ack && kind_q != CMD_INVAL) buf_q <= recall_data;
                    if (acked_all) state_q <= ST_DONE;
                end
                ST_DONE: begin
                    rsp_valid <= req_bit;
                    rsp_data  <= buf_q;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: at most one requester is answered per cycle.
    p_rsp_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));
    // R8: message pulses last a single cycle.
    p_cmd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid != '0) |=> (cmd_valid == '0));
    // R4: the requester never receives its own message.
    p_no_self_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid != '0) |-> ((cmd_valid & req_bit) == '0));
    // R7: no response while acknowledgements are outstanding.
    p_rsp_after_acks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q != '0) |-> (rsp_valid == '0));
endmodule

// File: rtl/dir_ctrl.sv
// Top of the directory coherence controller: request queue, transaction
// engine and entry store. Assumes each PE keeps at most one request open and
// acknowledges every message it receives.
module dir_ctrl #(
    parameter int          NUM_PE    = 4,
    parameter int          ADDR_W    = 3,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] INIT_BASE = 16'hA000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PE-1:0]        req_valid,
    input  logic [NUM_PE-1:0]        req_write,
    input  logic [NUM_PE*ADDR_W-1:0] req_addr,
    output logic [NUM_PE-1:0]        cmd_valid,
    output logic [1:0]               cmd_kind,
    output logic [ADDR_W-1:0]        cmd_addr,
    input  logic [NUM_PE-1:0]        ack_valid,
    input  logic [NUM_PE*DATA_W-1:0] ack_data,
    output logic [NUM_PE-1:0]        rsp_valid,
    output logic [DATA_W-1:0]        rsp_data
);
    localparam int PE_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

    logic              head_vld, head_wr, pop;
    logic [PE_W-1:0]   head_pe;
    logic [ADDR_W-1:0] head_addr, look_addr;
    logic [NUM_PE-1:0] rd_pres, wr_pres;
    logic              rd_dirty, wr_dirty, dir_we, mem_we;
    logic [DATA_W-1:0] rd_data, mem_wdata;

    dir_arrival_fifo #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_vec(req_valid), .push_wr(req_write), .push_addr(req_addr),
        .pop(pop), .head_vld(head_vld), .head_pe(head_pe),
        .head_wr(head_wr), .head_addr(head_addr)
    );

    dir_engine #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .head_vld(head_vld), .head_pe(head_pe), .head_wr(head_wr),
        .head_addr(head_addr), .pop(pop), .look_addr(look_addr),
        .rd_pres(rd_pres), .rd_dirty(rd_dirty), .rd_data(rd_data),
        .dir_we(dir_we), .wr_pres(wr_pres), .wr_dirty(wr_dirty),
        .mem_we(mem_we), .mem_wdata(mem_wdata),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .ack_valid(ack_valid), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    dir_entry_store #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                      .INIT_BASE(INIT_BASE)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(look_addr), .rd_pres(rd_pres), .rd_dirty(rd_dirty),
        .rd_data(rd_data), .wr_addr(look_addr), .dir_we(dir_we),
        .wr_pres(wr_pres), .wr_dirty(wr_dirty),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );
endmodule

// File: tb/tb_dir_ctrl.sv
// Directed bench: a cache model per PE answers messages; one task per scenario.
module tb_dir_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4, AW = 3, DW = 16;
    localparam logic [15:0] BASE = 16'hA000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0] req_valid = '0, req_write = '0, ack_valid = '0;
    logic [NP*AW-1:0] req_addr = '0;
    logic [NP*DW-1:0] ack_data = '0;
    logic [NP-1:0] cmd_valid, rsp_valid;
    logic [1:0] cmd_kind;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] rsp_data;

    dir_ctrl #(.NUM_PE(NP), .ADDR_W(AW), .DATA_W(DW), .INIT_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .ack_valid(ack_valid), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data));

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // PE cache model and logs.
    logic [DW-1:0] c_data [NP][1<<AW];
    logic          c_valid[NP][1<<AW];
    int  ack_delay[NP], due[NP], ack_cyc[NP], rsp_cyc[NP];
    logic [1:0] pend_kind[NP];
    logic [AW-1:0] pend_addr[NP];
    int  msg_cnt[NP];
    logic [1:0] msg_kind[NP];
    logic rsp_seen[NP], req_wr_l[NP];
    logic [AW-1:0] req_ad_l[NP];
    logic [DW-1:0] rsp_val[NP];
    int order[8]; int n_order = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Responder: acknowledge messages after a per-PE delay.
    initial begin
        for (int p = 0; p < NP; p++) begin due[p] = -1; ack_delay[p] = 0; msg_cnt[p] = 0; end
        forever begin
            @(negedge clk);
            ack_valid = '0;
            for (int p = 0; p < NP; p++) begin
                if (due[p] == 0) begin
                    ack_valid[p] = 1'b1;
                    ack_data[p*DW +: DW] = c_data[p][pend_addr[p]];
                    if (pend_kind[p] != 2'd1) c_valid[p][pend_addr[p]] = 1'b0;
                    ack_cyc[p] = cyc;
                    due[p] = -1;
                end else if (due[p] > 0) due[p]--;
            end
            for (int p = 0; p < NP; p++) begin
                if (cmd_valid[p]) begin
                    msg_cnt[p]++; msg_kind[p] = cmd_kind;
                    pend_kind[p] = cmd_kind; pend_addr[p] = cmd_addr;
                    due[p] = ack_delay[p];
                end
            end
        end
    end

    // Response monitor: logs order, data and updates the requester's cache.
    initial begin
        forever begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                if (rsp_valid[p]) begin
                    rsp_seen[p] = 1'b1; rsp_val[p] = rsp_data; rsp_cyc[p] = cyc;
                    if (n_order < 8) order[n_order] = p;
                    n_order++;
                    c_valid[req_ad_l[p]] = c_valid[req_ad_l[p]];
                    c_valid[p][req_ad_l[p]] = 1'b1;
                    c_data[p][req_ad_l[p]]  = rsp_data;
                end
            end
        end
    end

    task automatic clear_log();
        for (int p = 0; p < NP; p++) msg_cnt[p] = 0;
    endtask

    task automatic issue(input int p, input bit wr, input int a);
        rsp_seen[p] = 1'b0; req_wr_l[p] = wr; req_ad_l[p] = AW'(a);
        req_valid[p] = 1'b1; req_write[p] = wr; req_addr[p*AW +: AW] = AW'(a);
    endtask

    task automatic wait_rsp(input int p, input string tag);
        int t = 0;
        while (!rsp_seen[p] && t < 200) begin @(negedge clk); t++; end
        check(rsp_seen[p], {tag, " response arrived"}, 0, 1);
    endtask

    task automatic transact(input int p, input bit wr, input int a, input string tag);
        @(negedge clk); issue(p, wr, a);
        @(negedge clk); req_valid = '0;
        wait_rsp(p, tag);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(rsp_valid == '0, "R1 rsp idle", int'(rsp_valid), 0);
        check(cmd_valid == '0, "R1 cmd idle", int'(cmd_valid), 0);
    endtask

    task automatic t_read_clean();
        clear_log();
        transact(0, 1'b0, 2, "R2");
        check(rsp_val[0] == BASE + 2, "R1 R2 initial data", rsp_val[0], BASE + 2);
        transact(1, 1'b0, 2, "R2");
        check(msg_cnt[0] + msg_cnt[1] + msg_cnt[2] + msg_cnt[3] == 0,
              "R2 no messages", msg_cnt[0] + msg_cnt[1], 0);
    endtask

    task automatic t_write_clean();
        clear_log();
        transact(2, 1'b1, 2, "R4");
        check(msg_cnt[0] == 1 && msg_cnt[1] == 1, "R4 sharers invalidated", msg_cnt[0]*16 + msg_cnt[1], 17);
        check(msg_cnt[2] == 0 && msg_cnt[3] == 0, "R4 no stray message", msg_cnt[2]*16 + msg_cnt[3], 0);
        check(msg_kind[0] == 2'd0, "R4 kind invalidate", msg_kind[0], 0);
        check(rsp_val[2] == BASE + 2, "R4 data from store", rsp_val[2], BASE + 2);
        c_data[2][2] = 16'hBEEF;
    endtask

    task automatic t_read_dirty();
        clear_log();
        transact(3, 1'b0, 2, "R3");
        check(msg_cnt[2] == 1 && msg_kind[2] == 2'd1, "R3 recall-share to owner", msg_kind[2], 1);
        check(msg_cnt[0] + msg_cnt[1] == 0, "R3 owner only", msg_cnt[0] + msg_cnt[1], 0);
        check(rsp_val[3] == 16'hBEEF, "R3 owner data delivered", rsp_val[3], 16'hBEEF);
    endtask

    task automatic t_write_after_share();
        clear_log();
        transact(0, 1'b1, 2, "R6");
        check(msg_cnt[2] == 1 && msg_cnt[3] == 1, "R6 current sharers invalidated", msg_cnt[2]*16 + msg_cnt[3], 17);
        check(msg_cnt[1] == 0, "R6 cleared sharer untouched", msg_cnt[1], 0);
        c_data[0][2] = 16'h1234;
    endtask

    task automatic t_write_dirty();
        clear_log();
        transact(1, 1'b1, 2, "R5");
        check(msg_cnt[0] == 1 && msg_kind[0] == 2'd2, "R5 recall-inv to owner", msg_kind[0], 2);
        check(msg_cnt[2] + msg_cnt[3] == 0, "R5 owner only", msg_cnt[2] + msg_cnt[3], 0);
        check(rsp_val[1] == 16'h1234, "R5 recalled data", rsp_val[1], 16'h1234);
        c_data[1][2] = 16'h5555;
    endtask

    task automatic t_copy_back();
        transact(0, 1'b0, 2, "R3");
        check(rsp_val[0] == 16'h5555, "R3 second recall data", rsp_val[0], 16'h5555);
        clear_log();
        transact(3, 1'b0, 2, "R3");
        check(msg_cnt[0] + msg_cnt[1] + msg_cnt[2] + msg_cnt[3] == 0,
              "R3 clean after recall", msg_cnt[1], 0);
        check(rsp_val[3] == 16'h5555, "R3 store updated", rsp_val[3], 16'h5555);
    endtask

    task automatic t_late_acks();
        ack_delay[0] = 6; ack_delay[1] = 0;
        transact(1, 1'b0, 4, "R7");
        transact(0, 1'b0, 4, "R7");
        transact(2, 1'b1, 4, "R7");
        check(rsp_cyc[2] > ack_cyc[0], "R7 rsp after late ack", rsp_cyc[2], ack_cyc[0] + 1);
        ack_delay[0] = 0;
    endtask

    task automatic t_order();
        n_order = 0;
        @(negedge clk); issue(3, 1'b0, 5); issue(1, 1'b0, 6);
        @(negedge clk); req_valid = '0; issue(0, 1'b0, 7);
        @(negedge clk); req_valid = '0;
        wait_rsp(0, "R9");
        check(n_order == 3, "R8 one response each", n_order, 3);
        check(order[0] == 1 && order[1] == 3 && order[2] == 0, "R9 arrival order",
              order[0]*256 + order[1]*16 + order[2], 'h130);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) for (int a = 0; a < (1<<AW); a++) begin
            c_valid[p][a] = 1'b0; c_data[p][a] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_clean();
        t_write_clean();
        t_read_dirty();
        t_write_after_share();
        t_write_dirty();
        t_copy_back();
        t_late_acks();
        t_order();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        tests++; fails++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule